// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Tags

This block turns an asynchronous serial line into tagged characters for a receive queue. A fractional divider made from a 16-bit whole part and a 6-bit fraction produces a tick at sixteen times the bit rate. The line passes through a two-stage synchronizer. A receive state machine then recognises a start bit and confirms it half a bit later. It shifts in 5 to 8 data bits, least significant bit first, and checks the optional parity bit and the stop bit.

Each finished character becomes one write toward an external FIFO. The write carries the data beside four status flags: framing, parity, break and overrun. The FIFO storage is outside the block. The block only sees the FIFO's full indication and must not write while it is high. Software configures the divisor, the character length and the parity mode, and changes them only while the block is disabled.

Top module: `uart_rx_tagged`

## Requirements
- R1: The tick period in system clocks is `div_int` plus one extra clock whenever the 6-bit fraction accumulator wraps. Each period adds `div_frac` to the accumulator, so the mean period is div_int + div_frac/64. A `div_int` of 0 behaves as 1. Characters sent at 16 times that mean period are received correctly.
- R2: After reset, and while the line is idle high, `wr_en` stays low.
- R3: A low level seen while idle starts a start-bit check. On the 8th tick the line is sampled again. If it is high, the event is dropped, no write occurs and the receiver is idle again.
- R4: After an accepted start bit, one bit is sampled every 16 ticks. The number of data bits is 5 + `char_len` (char_len 0..3). Bits arrive LSB first, and data bits above the character length are written as zero.
- R5: With `par_en` high, one parity bit follows the data. `par_mode` selects the check: 0 even (data plus parity has an even number of ones), 1 odd, 2 parity bit must be 1, 3 parity bit must be 0. A mismatch sets the parity flag (bit 9).
- R6: A stop bit sampled low sets the framing flag (bit 8). The receiver then waits for the line to return high before it looks for a new start bit.
- R7: If every sampled position of a frame is low (start, data, parity and stop), the break flag (bit 10) is set together with the framing flag and the data is zero. Exactly one entry is written however long the line stays low.
- R8: A character that completes while `fifo_full` is high is not written. The next written entry carries the overrun flag (bit 11), and the flag is then cleared.
- R9: While `enable` is low the receiver is held idle and writes nothing. A partly received frame is discarded.
- R10: `wr_en` is a single-cycle pulse per character. `wr_entry` holds data in bits [7:0], framing in 8, parity in 9, break in 10 and overrun in 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Receiver enable; low holds the receiver idle |
| div_int | input | 16 | Whole part of the tick divisor |
| div_frac | input | 6 | Fraction of the tick divisor in 1/64 steps |
| char_len | input | 2 | Data bits per character minus 5 |
| par_en | input | 1 | A parity bit follows the data |
| par_mode | input | 2 | 0 even, 1 odd, 2 forced one, 3 forced zero |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| wr_en | output | 1 | Write strobe toward the receive FIFO |
| wr_entry | output | 12 | Tagged character: overrun, break, parity, framing, data |

## Verification
Some properties are checked on every cycle. Tick spacing stays within one clock of the programmed whole divisor. No write is issued into a full FIFO, and a disabled receiver writes nothing. Writes are single pulses, a break tag is always paired with a framing tag, and data bits above the character length are zero.

Other behaviour can only be shown by the bench's scenarios, which compare the written entries with values computed from the serial stimulus. These cover correct bit order, rejection of short glitches, each parity mode, the overrun tag landing on the following character, a single entry for a long break, and correct reception at fractional divisors.

// File: rtl/uart_rx_pkg.sv
// Shared types for the tagged serial receiver.
// Assumes an 8-bit data field; the character length code selects 5..8 bits.
package uart_rx_pkg;
    parameter int DATA_W = 8;
    parameter int LEN_W  = 2;
    parameter int OVS    = 16;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4,
        RX_HOLD  = 3'd5
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_EVEN  = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic              ovr;
        logic              brk;
        logic              pe;
        logic              fe;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // Returns 1 when the received parity bit disagrees with the selected mode.
    function automatic logic parity_bad(par_mode_e m, logic data_xor, logic pbit);
        logic bad;
        case (m)
            PAR_EVEN:  bad = data_xor ^ pbit;
            PAR_ODD:   bad = ~(data_xor ^ pbit);
            PAR_MARK:  bad = ~pbit;
            default:   bad = pbit;
        endcase
        return bad;
    endfunction
endpackage

// File: rtl/urx_baud_tick.sv
// Fractional oversampling tick generator.
// Each period lasts max(div_int,1) clocks, plus one clock when the fraction
// accumulator wrapped at the end of the previous period. Held in reset while
// en is low. Assumes the divisor only changes while en is low.
module urx_baud_tick #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick_o
);
    localparam int CW = INT_W + 1;

    logic [INT_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic              extra;
    logic [CW-1:0]     eff_div;
    logic [CW-1:0]     limit;
    logic [FRAC_W:0]   acc_sum;

    // Effective period length for the current tick.
    always_comb begin
        eff_div = (div_int == '0) ? CW'(1) : {1'b0, div_int};
        limit   = eff_div + CW'(extra);
        acc_sum = {1'b0, acc} + {1'b0, div_frac};
    end

    assign tick_o = en && (({1'b0, cnt} + CW'(1)) >= limit);

    // Period counter and fraction accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            acc   <= '0;
            extra <= 1'b0;
        end else if (tick_o) begin
            cnt   <= '0;
            acc   <= acc_sum[FRAC_W-1:0];
            extra <= acc_sum[FRAC_W];
        end else begin
            cnt   <= cnt + INT_W'(1);
        end
    end

    // Independent spacing counter used only by the check below.
    logic [CW:0] gap;
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick_o) gap <= '0;
        else if (gap != '1)          gap <= gap + (CW+1)'(1);
    end

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> ((gap + (CW+1)'(1)) >= {1'b0, eff_div}) &&
                   ((gap + (CW+1)'(1)) <= ({1'b0, eff_div} + (CW+1)'(1)))); // R1
endmodule

// File: rtl/urx_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// Resets to the idle-high level so no false start is seen after reset.
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the line through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/urx_frame_fsm.sv
// Receive state machine: start-bit confirmation at mid-bit, data shift
// (LSB first), parity and stop checks, break detection and the tagged write.
// Assumes rx_s is already synchronized and that configuration is stable
// while enable is high.
module urx_frame_fsm
    import uart_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            tick,
    input  logic            rx_s,
    input  logic [LEN_W-1:0] char_len,
    input  logic            par_en,
    input  logic [1:0]      par_mode,
    input  logic            fifo_full,
    output logic            wr_en,
    output rx_entry_t       wr_entry
);
    localparam int MIN_BITS = DATA_W - (2 ** LEN_W) + 1;
    localparam int CNT_W    = $clog2(OVS);
    localparam int BIT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  tcnt;
    logic [BIT_W-1:0]  bitn;
    logic [BIT_W-1:0]  nbits;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] aligned;
    logic              data_xor;
    logic              pbit;
    logic              all_low;
    logic              ovr_pend;
    logic              sample;

    // Character length and alignment of the shifted data.
    always_comb begin
        nbits   = BIT_W'(MIN_BITS) + BIT_W'(char_len);
        aligned = shreg >> (BIT_W'(DATA_W) - nbits);
        sample  = tick && (tcnt == LAST);
    end

    // Frame sequencing and the tagged write.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state    <= RX_IDLE;
            tcnt     <= '0;
            bitn     <= '0;
            shreg    <= '0;
            data_xor <= 1'b0;
            pbit     <= 1'b0;
            all_low  <= 1'b1;
            ovr_pend <= 1'b0;
            wr_en    <= 1'b0;
            wr_entry <= '0;
        end else begin
            wr_en <= 1'b0;
            if (tick && state != RX_IDLE && state != RX_HOLD) tcnt <= tcnt + CNT_W'(1);
            case (state)
                RX_IDLE: begin
                    if (!rx_s) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick && tcnt == MID) begin
                        tcnt <= '0;
                        if (!rx_s) begin
                            state    <= RX_DATA;
                            bitn     <= '0;
                            data_xor <= 1'b0;
                            all_low  <= 1'b1;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end
                end
                RX_DATA: begin
                    if (sample) begin
                        shreg    <= {rx_s, shreg[DATA_W-1:1]};
                        data_xor <= data_xor ^ rx_s;
                        all_low  <= all_low & ~rx_s;
                        if (bitn == nbits - BIT_W'(1)) state <= par_en ? RX_PAR : RX_STOP;
                        else                           bitn  <= bitn + BIT_W'(1);
                    end
                end
                RX_PAR: begin
                    if (sample) begin
                        pbit    <= rx_s;
                        all_low <= all_low & ~rx_s;
                        state   <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (sample) begin
                        if (fifo_full) begin
                            ovr_pend <= 1'b1;
                        end else begin
                            wr_en         <= 1'b1;
                            wr_entry.data <= (all_low && !rx_s) ? '0 : aligned;
                            wr_entry.fe   <= ~rx_s;
                            wr_entry.brk  <= all_low & ~rx_s;
                            wr_entry.pe   <= par_en &
                                             parity_bad(par_mode_e'(par_mode), data_xor, pbit);
                            wr_entry.ovr  <= ovr_pend;
                            ovr_pend      <= 1'b0;
                        end
                        state <= rx_s ? RX_IDLE : RX_HOLD;
                    end
                end
                RX_HOLD: begin
                    if (rx_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && sample && fifo_full) |=> !wr_en); // R8
    AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == RX_IDLE) && !wr_en); // R9
    AST_BREAK_HAS_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_entry.brk) |-> (wr_entry.fe && wr_entry.data == '0)); // R7
    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_entry.data >> nbits) == '0)); // R4
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R10
    AST_HOLD_AFTER_LOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && sample && !rx_s && enable) |=> (state == RX_HOLD)); // R6
endmodule

// File: rtl/uart_rx_tagged.sv
// Top level of the tagged serial receiver: tick generator, line
// synchronizer and frame state machine. The FIFO itself lives outside;
// the block only writes when fifo_full is low.
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int DIV_INT_W  = 16,
    parameter int DIV_FRAC_W = 6,
    parameter int SYNC_STAGES = 2,
    localparam int ENTRY_W   = DATA_W + 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [DIV_INT_W-1:0]  div_int,
    input  logic [DIV_FRAC_W-1:0] div_frac,
    input  logic [LEN_W-1:0]      char_len,
    input  logic                  par_en,
    input  logic [1:0]            par_mode,
    input  logic                  rx_in,
    input  logic                  fifo_full,
    output logic                  wr_en,
    output logic [ENTRY_W-1:0]    wr_entry
);
    logic      tick;
    logic      rx_s;
    rx_entry_t entry;

    urx_baud_tick #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .div_int  (div_int),
        .div_frac (div_frac),
        .tick_o   (tick)
    );

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_in),
        .q_sync  (rx_s)
    );

    urx_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .rx_s      (rx_s),
        .char_len  (char_len),
        .par_en    (par_en),
        .par_mode  (par_mode),
        .fifo_full (fifo_full),
        .wr_en     (wr_en),
        .wr_entry  (entry)
    );

    assign wr_entry = entry;
endmodule

// File: tb/uart_rx_tagged_tb_top.sv
// Scoreboard bench: the driver serialises characters and queues the entry
// each should produce; the monitor pops and compares every write.
module uart_rx_tagged_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] div_int = 16'd1;
    logic [5:0]  div_frac = 6'd0;
    logic [1:0]  char_len = 2'd3;
    logic        par_en = 1'b0;
    logic [1:0]  par_mode = 2'd0;
    logic        rx_in = 1'b1;
    logic        fifo_full = 1'b0;
    logic        wr_en;
    logic [11:0] wr_entry;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int bt = 16;
    logic [11:0] exp_q[$];

    always #2.5 clk = ~clk;

    uart_rx_tagged dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_int(div_int),
        .div_frac(div_frac), .char_len(char_len), .par_en(par_en),
        .par_mode(par_mode), .rx_in(rx_in), .fifo_full(fifo_full),
        .wr_en(wr_en), .wr_entry(wr_entry)
    );

    // Monitor: compare each write with the oldest expected entry.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected write: got %h expected none", wr_entry);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                if (wr_entry !== e) begin
                    errors++;
                    $display("FAIL R10 entry mismatch: got %h expected %h", wr_entry, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic hold_bit(input logic v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic good_parity(input logic [7:0] d, input int nb, input logic [1:0] m);
        logic x;
        x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        case (m)
            2'd0: return x;
            2'd1: return ~x;
            2'd2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Driver: serialise one character and queue its expected entry.
    task automatic send(input logic [7:0] d, input logic flip_par, input logic stop_v,
                        input logic expect_it, input logic ovr);
        int nb;
        logic pb;
        logic [7:0] dm;
        nb = 5 + char_len;
        pb = good_parity(d, nb, par_mode) ^ flip_par;
        dm = d & 8'((1 << nb) - 1);
        if (expect_it) exp_q.push_back({ovr, 1'b0, par_en & flip_par, ~stop_v, dm});
        hold_bit(1'b0, bt);
        for (int i = 0; i < nb; i++) hold_bit(d[i], bt);
        if (par_en) hold_bit(pb, bt);
        hold_bit(stop_v, bt);
        hold_bit(1'b1, 2 * bt);
    endtask

    task automatic expect_drained(input string tag);
        repeat (40) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing writes: got %0d pending expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2: no writes after reset with the line idle.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            checks++;
            if (wr_en !== 1'b0) begin
                errors++;
                $display("FAIL R2 reset state: got wr_en %b expected 0", wr_en);
            end
        end
        enable = 1'b1;
        repeat (5) @(negedge clk);

        // R4 R10: 8-bit characters, LSB first.
        send(8'hA5, 0, 1, 1, 0);
        send(8'h3C, 0, 1, 1, 0);
        send(8'h01, 0, 1, 1, 0);
        expect_drained("R4");

        // R4: shorter character lengths, upper bits zero.
        char_len = 2'd0; send(8'hF5, 0, 1, 1, 0);
        char_len = 2'd2; send(8'hDA, 0, 1, 1, 0);
        char_len = 2'd3;
        expect_drained("R4");

        // R5: each parity mode, good and corrupted.
        par_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            par_mode = 2'(m);
            send(8'h6B, 0, 1, 1, 0);
            send(8'h6B, 1, 1, 1, 0);
        end
        par_mode = 2'd0;
        par_en = 1'b0;
        expect_drained("R5");

        // R6: framing error, then a clean character.
        send(8'h55, 0, 0, 1, 0);
        send(8'h81, 0, 1, 1, 0);
        expect_drained("R6");

        // R7: long break yields one entry; odd parity also flags parity.
        par_en = 1'b1; par_mode = 2'd1;
        exp_q.push_back(12'b0111_0000_0000);
        hold_bit(1'b0, 40 * bt);
        hold_bit(1'b1, 3 * bt);
        par_en = 1'b0; par_mode = 2'd0;
        send(8'h7E, 0, 1, 1, 0);
        expect_drained("R7");

        // R3: glitch shorter than half a bit is rejected.
        hold_bit(1'b0, 4);
        hold_bit(1'b1, 3 * bt);
        expect_drained("R3");
        send(8'hC3, 0, 1, 1, 0);
        expect_drained("R3");

        // R8: character lost while full; next one tagged overrun, then cleared.
        fifo_full = 1'b1;
        send(8'h11, 0, 1, 0, 0);
        fifo_full = 1'b0;
        send(8'h22, 0, 1, 1, 1);
        send(8'h33, 0, 1, 1, 0);
        expect_drained("R8");

        // R9: disable mid-frame discards it; a frame while disabled is ignored.
        hold_bit(1'b0, bt);
        hold_bit(1'b1, bt);
        hold_bit(1'b0, bt);
        enable = 1'b0;
        hold_bit(1'b1, bt);
        send(8'h99, 0, 1, 0, 0);
        expect_drained("R9");
        enable = 1'b1;
        send(8'h4D, 0, 1, 1, 0);
        expect_drained("R9");

        // R1: fractional divisors 2.5 and 3.25 (ticks of 2/3 and 3/3/3/4 clocks).
        enable = 1'b0; div_int = 16'd2; div_frac = 6'd32; bt = 40;
        @(negedge clk); enable = 1'b1;
        send(8'hB7, 0, 1, 1, 0);
        send(8'h2E, 0, 1, 1, 0);
        expect_drained("R1");
        enable = 1'b0; div_int = 16'd3; div_frac = 6'd16; bt = 52;
        @(negedge clk); enable = 1'b1;
        send(8'hE1, 0, 1, 1, 0);
        expect_drained("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule